// File: doc/BRIEF.md
# Half-Duty LCD Waveform Generator

This block produces the drive codes for a multiplexed segment display with two common lines and a parameterised number of segment lines (28 by default, 56 segments). Every output is a two-bit level code: low, middle or high. A later analog stage turns each code into a voltage. A frame is split into four equal phases. Each common is selected once at positive polarity and once at inverted polarity. The unselected common sits at the middle level, so every pixel averages to zero volts over a frame.

Segment data arrives over a simple digit-write port. Each digit covers four segment lines and two bits per line, one bit per common. Writes land in a pending store and are copied into the displayed store at the next phase boundary, so a phase never changes its data halfway through. The top four segment lines can be switched as a group into a plain output mode. In that mode they carry either a port register or a general-purpose latch, chosen by a select input. A system reset blanks the segments while the commons keep running. A backup input pulls every output low.

Top module: `lcd_half_duty_drv`

## Requirements
- R1: Level codes are 2'b00 low, 2'b01 middle and 2'b10 high. The code 2'b11 never appears on any output.
- R2: The phase timer runs from the release of `por_n` only. Each phase lasts CLK_HZ/(4*FRAME_HZ) clocks, and the phases repeat in the order 0,1,2,3. The common levels are: phase 0, common 0 high; phase 1, common 1 high; phase 2, common 0 low; phase 3, common 1 low. In every phase the other common is at the middle level. Common c drives `com_lvl[2c+1:2c]`.
- R3: Segment line s drives `seg_lvl[2s+1:2s]`. When its stored bit for the selected common is 1 (on), it drives the level opposite to that common (high↔low). When the bit is 0 (off), it drives the same level as that common.
- R4: A cycle with `wr_en` high and `wr_digit` = d < NUM_SEG/4 stores, for k = 0..3, `wr_bits[2k]` as the common-0 bit and `wr_bits[2k+1]` as the common-1 bit of segment line 4d+k. A digit index at or above NUM_SEG/4 changes nothing.
- R5: Written data first appears in the phase that starts at the next phase boundary. The phase that is running keeps its old data.
- R6: While `rst_n` is low, all stored segment bits are cleared and every segment line drives the off waveform. Shared-pin port mode is cleared. The commons keep following R2.
- R7: While `backup` is high, every common and segment output is 2'b00. This overrides reset and port mode.
- R8: A `pmode_set` pulse turns port mode on and a `pmode_clr` pulse turns it off. When both arrive in the same cycle, clear wins. In port mode, segment line NUM_SEG-4+j drives high when its source bit j is 1 and low when it is 0. The source is `port_data` when `port_src` is 1 and `gp_latch` when it is 0. Lines below NUM_SEG-4 are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low; clears the phase timer |
| rst_n | input | 1 | System reset, active low; clears data and port mode |
| backup | input | 1 | Forces all outputs low |
| wr_en | input | 1 | Digit write strobe |
| wr_digit | input | $clog2(NUM_SEG/4) | Digit index to write |
| wr_bits | input | 8 | Two bits per segment line of the digit |
| pmode_set | input | 1 | Turn shared-pin port mode on |
| pmode_clr | input | 1 | Turn shared-pin port mode off |
| port_src | input | 1 | Port-mode source: 1 port register, 0 latch |
| port_data | input | 4 | Port register contents |
| gp_latch | input | 4 | General-purpose output latch contents |
| com_lvl | output | 4 | Level codes of the two commons |
| seg_lvl | output | 2*NUM_SEG | Level codes of the segment lines |

## Verification
The bench writes mid-phase and checks the same phase again. A design that wrote straight through to the displayed store would change the pixels early. It writes the first digit index past the end. A design with a wrapping or truncated decode would corrupt a real digit. It pulses set and clear together and expects the shared pins to stay in display mode. It holds reset across several phases and checks that the commons keep alternating while every segment follows the selected common; a timer tied to the system reset would freeze them. Backup is raised while port mode is on, so a force that missed the shared pins would show up.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_MID  = 2'b01,
      LVL_HIGH = 2'b10
   } lvl_e;

   // Phase index: bit 1 = inverted polarity, bit 0 = which common is selected
   typedef struct packed {
      logic inverted;
      logic sel_com;
   } phase_s;

   function automatic lvl_e lvl_flip(input lvl_e l);
      return (l == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
   endfunction
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer
   import lcd_drv_pkg::*;
#(
   parameter int CLK_HZ   = 4_000_000,
   parameter int FRAME_HZ = 100
)(
   input  logic   clk,
   input  logic   por_n,
   output phase_s phase,
   output logic   tick
);
   localparam int PHASE_CYCLES = CLK_HZ / (4 * FRAME_HZ);
   localparam int CW           = $clog2(PHASE_CYCLES);

   if (PHASE_CYCLES < 2) begin : g_bad_rate
      $error("phase must last at least two clocks");
   end
   if (CLK_HZ % (4 * FRAME_HZ) != 0) begin : g_bad_ratio
      $error("clock must divide evenly into four phases per frame");
   end

   logic [CW-1:0] cnt_q;
   logic [1:0]    phase_q;

   assign tick  = (cnt_q == CW'(PHASE_CYCLES - 1));
   assign phase = phase_s'(phase_q);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q   <= '0;
         phase_q <= '0;
      end else if (tick) begin
         cnt_q   <= '0;
         phase_q <= phase_q + 2'd1;
      end else begin
         cnt_q   <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/lcd_seg_store.sv
module lcd_seg_store #(
   parameter int NUM_SEG    = 28,
   parameter int DIGIT_SEGS = 4
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic                         wr_en,
   input  logic [$clog2(NUM_SEG/DIGIT_SEGS)-1:0] wr_digit,
   input  logic [2*DIGIT_SEGS-1:0]      wr_bits,
   output logic [1:0][NUM_SEG-1:0]      act_bits
);
   localparam int NUM_DIGITS = NUM_SEG / DIGIT_SEGS;
   localparam int DW         = $clog2(NUM_DIGITS);

   if (NUM_SEG % DIGIT_SEGS != 0) begin : g_bad_split
      $error("segment count must be a whole number of digits");
   end
   if (NUM_DIGITS < 2) begin : g_bad_digits
      $error("at least two digits are required");
   end

   logic [1:0][NUM_SEG-1:0] pend_q, pend_nx;

   // Merge a digit write into the pending copy
   always_comb begin
      pend_nx = pend_q;
      for (int d = 0; d < NUM_DIGITS; d++) begin
         if (wr_en && (wr_digit == DW'(d))) begin
            for (int k = 0; k < DIGIT_SEGS; k++) begin
               pend_nx[0][d*DIGIT_SEGS + k] = wr_bits[2*k];
               pend_nx[1][d*DIGIT_SEGS + k] = wr_bits[2*k + 1];
            end
         end
      end
   end

   // Displayed copy only moves at a phase boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         act_bits <= '0;
      end else begin
         pend_q <= pend_nx;
         if (tick) act_bits <= pend_nx;
      end
   end
endmodule

// File: rtl/lcd_wave_map.sv
module lcd_wave_map
   import lcd_drv_pkg::*;
#(
   parameter int NUM_SEG = 28
)(
   input  phase_s                  phase,
   input  logic [1:0][NUM_SEG-1:0] act_bits,
   output logic [3:0]              com_raw,
   output logic [2*NUM_SEG-1:0]    seg_raw
);
   lvl_e sel_lvl;
   assign sel_lvl = phase.inverted ? LVL_LOW : LVL_HIGH;

   for (genvar c = 0; c < 2; c++) begin : g_com
      assign com_raw[2*c +: 2] = (phase.sel_com == 1'(c)) ? sel_lvl : LVL_MID;
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic on;
      assign on = act_bits[phase.sel_com][s];
      assign seg_raw[2*s +: 2] = on ? lvl_flip(sel_lvl) : sel_lvl;
   end
endmodule

// File: rtl/lcd_half_duty_drv.sv
module lcd_half_duty_drv
   import lcd_drv_pkg::*;
#(
   parameter int CLK_HZ      = 4_000_000,
   parameter int FRAME_HZ    = 100,
   parameter int NUM_SEG     = 28,
   parameter int DIGIT_SEGS  = 4,
   parameter int SHARED_SEGS = 4
)(
   input  logic                                  clk,
   input  logic                                  por_n,
   input  logic                                  rst_n,
   input  logic                                  backup,
   input  logic                                  wr_en,
   input  logic [$clog2(NUM_SEG/DIGIT_SEGS)-1:0] wr_digit,
   input  logic [2*DIGIT_SEGS-1:0]               wr_bits,
   input  logic                                  pmode_set,
   input  logic                                  pmode_clr,
   input  logic                                  port_src,
   input  logic [SHARED_SEGS-1:0]                port_data,
   input  logic [SHARED_SEGS-1:0]                gp_latch,
   output logic [3:0]                            com_lvl,
   output logic [2*NUM_SEG-1:0]                  seg_lvl
);
   localparam int SHARED_BASE = NUM_SEG - SHARED_SEGS;

   if (SHARED_SEGS < 1 || SHARED_SEGS > NUM_SEG) begin : g_bad_shared
      $error("shared group must be between one line and all lines");
   end

   phase_s                  phase;
   logic                    phase_tick;
   logic [1:0][NUM_SEG-1:0] act_bits;
   logic [3:0]              com_raw;
   logic [2*NUM_SEG-1:0]    seg_raw;
   logic [2*NUM_SEG-1:0]    seg_mux;
   logic                    pmode_q;

   lcd_phase_timer #(.CLK_HZ(CLK_HZ), .FRAME_HZ(FRAME_HZ)) u_timer (
      .clk   (clk),
      .por_n (por_n),
      .phase (phase),
      .tick  (phase_tick)
   );

   lcd_seg_store #(.NUM_SEG(NUM_SEG), .DIGIT_SEGS(DIGIT_SEGS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (phase_tick),
      .wr_en    (wr_en),
      .wr_digit (wr_digit),
      .wr_bits  (wr_bits),
      .act_bits (act_bits)
   );

   lcd_wave_map #(.NUM_SEG(NUM_SEG)) u_map (
      .phase    (phase),
      .act_bits (act_bits),
      .com_raw  (com_raw),
      .seg_raw  (seg_raw)
   );

   // Group mode flag for the shared lines; clear dominates set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pmode_q <= 1'b0;
      else if (pmode_clr) pmode_q <= 1'b0;
      else if (pmode_set) pmode_q <= 1'b1;
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_pin
      if (s >= SHARED_BASE) begin : g_shared
         logic src_bit;
         assign src_bit = port_src ? port_data[s - SHARED_BASE] : gp_latch[s - SHARED_BASE];
         assign seg_mux[2*s +: 2] = pmode_q ? (src_bit ? LVL_HIGH : LVL_LOW)
                                            : seg_raw[2*s +: 2];
      end else begin : g_plain
         assign seg_mux[2*s +: 2] = seg_raw[2*s +: 2];
      end
   end

   assign com_lvl = backup ? '0 : com_raw;
   assign seg_lvl = backup ? '0 : seg_mux;
endmodule

// File: rtl/lcd_drv_chk.sv
module lcd_drv_chk #(
   parameter int NUM_SEG = 28
)(
   input logic                 clk,
   input logic                 por_n,
   input logic                 rst_n,
   input logic                 backup,
   input logic                 pmode_set,
   input logic                 pmode_clr,
   input logic                 tick,
   input logic                 pmode_q,
   input logic [3:0]           com_lvl,
   input logic [2*NUM_SEG-1:0] seg_lvl
);
   logic [1:0] sel_com_lvl;
   assign sel_com_lvl = (com_lvl[1:0] == 2'b01) ? com_lvl[3:2] : com_lvl[1:0];

   assert_code_legal_R1: assert property (@(posedge clk) disable iff (!por_n)
      !backup |-> (com_lvl[1:0] != 2'b11 && com_lvl[3:2] != 2'b11 && seg_lvl[1:0] != 2'b11));

   assert_one_com_mid_R2: assert property (@(posedge clk) disable iff (!por_n)
      !backup |-> ((com_lvl[1:0] == 2'b01) != (com_lvl[3:2] == 2'b01)));

   assert_com_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
      (!tick && !backup) |=> (backup || $stable(com_lvl)));

   assert_reset_seg_off_R6: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n && !backup) |-> (seg_lvl[1:0] == sel_com_lvl));

   assert_backup_low_R7: assert property (@(posedge clk) disable iff (!por_n)
      backup |-> (com_lvl == '0 && seg_lvl == '0));

   assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      pmode_clr |=> !pmode_q);

   assert_set_mode_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (pmode_set && !pmode_clr) |=> pmode_q);
endmodule

bind lcd_half_duty_drv lcd_drv_chk #(.NUM_SEG(NUM_SEG)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .backup    (backup),
   .pmode_set (pmode_set),
   .pmode_clr (pmode_clr),
   .tick      (phase_tick),
   .pmode_q   (pmode_q),
   .com_lvl   (com_lvl),
   .seg_lvl   (seg_lvl)
);

// File: tb/test_lcd_half_duty_drv.sv
`timescale 1ns/1ps
module test_lcd_half_duty_drv;
   localparam int CLK_HZ   = 80_000;
   localparam int FRAME_HZ = 100;
   localparam int PC       = CLK_HZ / (4 * FRAME_HZ);
   localparam int NS       = 28;
   localparam int NSH      = 4;
   localparam int BASE     = NS - NSH;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          por_n, rst_n, backup, wr_en, pmode_set, pmode_clr, port_src;
   logic [2:0]    wr_digit;
   logic [7:0]    wr_bits;
   logic [3:0]    port_data, gp_latch;
   logic [3:0]    com_lvl;
   logic [2*NS-1:0] seg_lvl;

   lcd_half_duty_drv #(.CLK_HZ(CLK_HZ), .FRAME_HZ(FRAME_HZ), .NUM_SEG(NS),
                       .DIGIT_SEGS(4), .SHARED_SEGS(NSH)) i_lcd_half_duty_drv (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .backup(backup),
      .wr_en(wr_en), .wr_digit(wr_digit), .wr_bits(wr_bits),
      .pmode_set(pmode_set), .pmode_clr(pmode_clr), .port_src(port_src),
      .port_data(port_data), .gp_latch(gp_latch),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;
   logic [1:0][NS-1:0] m_pend = '0;
   logic [1:0][NS-1:0] m_act  = '0;
   logic m_mode = 1'b0;

   typedef struct {
      logic [59:0] v;
      string       tag;
   } item_t;
   item_t sb[$];

   // Reference phase count and displayed-data model
   always @(posedge clk) begin
      if (!por_n) cyc <= 0;
      else begin
         if (!rst_n) m_act <= '0;
         else if (cyc % PC == PC - 1) m_act <= m_pend;
         cyc <= cyc + 1;
      end
   end

   function automatic logic [59:0] model(int ph);
      logic [3:0]      c;
      logic [2*NS-1:0] s;
      logic [1:0]      a, o, l;
      int              sc;
      sc = ph % 2;
      a  = (ph >= 2) ? 2'b00 : 2'b10;
      o  = (ph >= 2) ? 2'b10 : 2'b00;
      for (int k = 0; k < 2; k++) c[2*k +: 2] = (k == sc) ? a : 2'b01;
      for (int i = 0; i < NS; i++) begin
         l = m_act[sc][i] ? o : a;
         if (m_mode && i >= BASE)
            l = (port_src ? port_data[i-BASE] : gp_latch[i-BASE]) ? 2'b10 : 2'b00;
         s[2*i +: 2] = l;
      end
      if (backup) begin c = '0; s = '0; end
      return {c, s};
   endfunction

   // Monitor: pop expected items and compare with the outputs
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         total++;
         if ({com_lvl, seg_lvl} !== it.v) begin
            bad++;
            $display("FAIL %s: got %h expected %h", it.tag, {com_lvl, seg_lvl}, it.v);
         end
      end
   end

   task automatic expect_mid(string tag);
      do @(negedge clk); while (cyc % PC != PC / 2);
      sb.push_back('{v: model((cyc / PC) % 4), tag: tag});
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_off(int off);
      do @(negedge clk); while (cyc % PC != off);
   endtask

   task automatic write_digit(int d, logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_digit = 3'(d); wr_bits = b;
      if (d < NS / 4) begin
         for (int k = 0; k < 4; k++) begin
            m_pend[0][d*4 + k] = b[2*k];
            m_pend[1][d*4 + k] = b[2*k + 1];
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_mode(bit s, bit c);
      @(negedge clk);
      pmode_set = s; pmode_clr = c;
      @(negedge clk);
      pmode_set = 1'b0; pmode_clr = 1'b0;
      if (c) m_mode = 1'b0;
      else if (s) m_mode = 1'b1;
   endtask

   initial begin
      por_n = 1'b0; rst_n = 1'b0; backup = 1'b0; wr_en = 1'b0;
      wr_digit = '0; wr_bits = '0; pmode_set = 1'b0; pmode_clr = 1'b0;
      port_src = 1'b0; port_data = '0; gp_latch = '0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;

      // Reset state: segments off, commons cycling through all four phases
      for (int ph = 0; ph < 4; ph++)
         expect_mid($sformatf("R2 R6 reset waveform phase %0d", ph));

      @(negedge clk); rst_n = 1'b1;

      // Writes mid-phase must wait for the boundary
      wait_off(10);
      write_digit(0, 8'hA5);
      write_digit(3, 8'h3C);
      write_digit(6, 8'hFF);
      expect_mid("R5 write held until boundary");
      for (int ph = 0; ph < 4; ph++)
         expect_mid($sformatf("R1 R3 pattern frame step %0d", ph));

      // Digit index past the end is dropped, valid one lands
      wait_off(10);
      write_digit(7, 8'hFF);
      write_digit(1, 8'h5A);
      expect_mid("R5 second write held");
      expect_mid("R4 out-of-range digit ignored a");
      expect_mid("R4 out-of-range digit ignored b");

      // Shared-pin group mode
      port_data = 4'b1010; gp_latch = 4'b0110; port_src = 1'b1;
      pulse_mode(1'b1, 1'b0);
      expect_mid("R8 port register source");
      port_src = 1'b0;
      expect_mid("R8 latch source");
      pulse_mode(1'b1, 1'b1);
      expect_mid("R8 clear wins over set");
      pulse_mode(1'b1, 1'b0);

      // Backup forcing with port mode active
      @(negedge clk); backup = 1'b1;
      expect_mid("R7 backup forces low");
      @(negedge clk); backup = 1'b0;
      expect_mid("R7 R8 outputs return after backup");

      // Reset in operation
      @(negedge clk); rst_n = 1'b0; m_pend = '0; m_mode = 1'b0;
      expect_mid("R6 reset clears data and mode");
      expect_mid("R6 commons keep running in reset");
      @(negedge clk); rst_n = 1'b1;
      expect_mid("R6 blank after reset release");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule